// File: doc/BRIEF.md
# Countdown Alarm Timer

This block sits next to a real-time clock and counts an interval down to zero. Software writes the interval as days, hours, minutes and seconds into a single count register. It sets a run bit, and every pulse on the external one-second `tick` input then takes one second off the interval. A borrow runs from seconds into minutes, into hours and into days. When the last second expires, the counter stops at zero and raises a sticky pending flag. If the interrupt-enable bit is set, the flag also appears on the level `irq` output.

A simple register bus gives access to the block. A write is a one-cycle strobe with `reg_en` and `reg_we` both high. Reads are combinational from `reg_addr`. Four word offsets are decoded: count at 0x0C, run control at 0x14, interrupt enable at 0x18 and status at 0x1C. Any other offset reads as zero. The count word packs seconds into bits [5:0], minutes into [13:8], hours into [20:16] and days into the field that starts at bit 21. With the default `DAY_W` of 8, the day field is bits [28:21] and covers 0 to 255.

Top module: `rtc_countdown_alarm`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The count word written at 0x0C reads back field for field: seconds [5:0], minutes [13:8], hours [20:16], days [28:21] (0 to 255). Offset 0x14 reads back bit 8, offset 0x18 reads back bit 0, and unmapped offsets read zero.
- R3: The count changes on a `tick` only while bit 8 at 0x14 is set. Ticks with bit 8 clear, including a control word that has only bit 0 set, leave the count unchanged.
- R4: Each accepted tick removes one second. At seconds 0 the seconds reload to 59 and minutes borrow. At minutes 0 the minutes reload to 59 and hours borrow. At hours 0 the hours reload to 23 and days borrow.
- R5: The tick that brings the count to all-zero sets the pending flag (status bit 0 at 0x1C). The counter then stays at zero on later ticks and never wraps.
- R6: `irq` is high exactly while both the pending flag and bit 0 at 0x18 are set. It stays high until one of them clears.
- R7: Writing 1 to status bit 0 clears the pending flag, and writing 0 there has no effect. When a clear and the final tick fall in the same cycle, the flag ends up set.
- R8: A count write takes effect in the next cycle even while the counter runs. It wins over a tick in the same cycle and does not clear a pending flag.
- R9: With zero written to the count, the run control and the interrupt enable, ticks produce no pending flag and no interrupt. Loading zero with the run bit set also produces no pending flag.
- R10: At day and hour boundaries the borrow crosses the largest fields: 1d 0:00:00 becomes 0d 23:59:59, and 255d 0:00:00 becomes 254d 23:59:59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| reg_en | input | 1 | Bus access strobe |
| reg_we | input | 1 | Bus write qualifier |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt: pending AND interrupt enable |

## Verification
The assertions assume that software loads legal field values: seconds and minutes below 60 and hours below 24. Under that assumption, the claim that the seconds field stays in range is meaningful. They also assume that `tick` is a short pulse sampled on the clock, so at most one second is removed per cycle. Every interval the stimulus loads is derived from a count of remaining seconds, so the fields are always legal. The bench holds `tick` high for exactly one cycle per step. Bus writes and ticks are applied on the falling edge, and the one deliberate same-cycle collision (final tick together with a status clear, or a count write together with a tick) is built on purpose to test priority.

// File: rtl/rtc_countdown_alarm.sv
module rtc_countdown_alarm #(
  parameter int ADDR_W = 5,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_RUN = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(28);
  localparam int PAD_W = 11 - DAY_W;

  logic [5:0]       sec_q, min_q;
  logic [4:0]       hr_q;
  logic [DAY_W-1:0] day_q;
  logic             run_q, ien_q, pend_q;

  logic wr, cnt_wr, sta_clr, zero, step, last;
  logic [31:0] cnt_word;

  assign wr      = reg_en & reg_we;
  assign cnt_wr  = wr && reg_addr == A_CNT;
  assign sta_clr = wr && reg_addr == A_STA && reg_wdata[0];
  assign zero    = sec_q == '0 && min_q == '0 && hr_q == '0 && day_q == '0;
  assign step    = tick && run_q && !zero && !cnt_wr;
  assign last    = step && sec_q == 6'd1 && min_q == '0 && hr_q == '0 && day_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (cnt_wr) begin
      sec_q <= reg_wdata[5:0];
      min_q <= reg_wdata[13:8];
      hr_q  <= reg_wdata[20:16];
      day_q <= reg_wdata[21 +: DAY_W];
    end else if (step) begin
      if (sec_q != '0) begin
        sec_q <= sec_q - 6'd1;
      end else begin
        sec_q <= 6'd59;
        if (min_q != '0) begin
          min_q <= min_q - 6'd1;
        end else begin
          min_q <= 6'd59;
          if (hr_q != '0) begin
            hr_q <= hr_q - 5'd1;
          end else begin
            hr_q  <= 5'd23;
            day_q <= day_q - DAY_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr && reg_addr == A_RUN) run_q <= reg_wdata[8];
      if (wr && reg_addr == A_IEN) ien_q <= reg_wdata[0];
      if (last)         pend_q <= 1'b1;
      else if (sta_clr) pend_q <= 1'b0;
    end
  end

  assign cnt_word = {{PAD_W{1'b0}}, day_q, hr_q, 2'b00, min_q, 2'b00, sec_q};

  always_comb begin
    case (reg_addr)
      A_CNT:   reg_rdata = cnt_word;
      A_RUN:   reg_rdata = {23'd0, run_q, 8'd0};
      A_IEN:   reg_rdata = {31'd0, ien_q};
      A_STA:   reg_rdata = {31'd0, pend_q};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = pend_q & ien_q;
endmodule

// File: rtl/rtc_countdown_alarm_chk.sv
module rtc_countdown_alarm_chk #(
  parameter int ADDR_W = 5,
  parameter int DAY_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic              run_q,
  input logic              ien_q,
  input logic              pend_q,
  input logic [5:0]        sec_q,
  input logic [5:0]        min_q,
  input logic [4:0]        hr_q,
  input logic [DAY_W-1:0]  day_q
);
  logic wr_cnt, wr_ien, clr;
  logic [DAY_W+16:0] cnt;
  assign wr_cnt = reg_en && reg_we && reg_addr == ADDR_W'(12);
  assign wr_ien = reg_en && reg_we && reg_addr == ADDR_W'(24);
  assign clr    = reg_en && reg_we && reg_addr == ADDR_W'(28) && reg_wdata[0];
  assign cnt    = {day_q, hr_q, min_q, sec_q};

  p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run_q) && !wr_cnt |=> $stable(cnt));

  p_sec_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q <= 6'd59 && !wr_cnt |=> sec_q <= 6'd59);

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 && !wr_cnt |=> cnt == '0);

  p_pend_from_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(tick && run_q && !wr_cnt));

  p_irq_needs_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_q && ien_q);

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr && !wr_ien |=> irq);

  p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr |=> pend_q);
endmodule

bind rtc_countdown_alarm rtc_countdown_alarm_chk #(.ADDR_W(ADDR_W), .DAY_W(DAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .run_q(run_q),
  .ien_q(ien_q), .pend_q(pend_q), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q),
  .day_q(day_q)
);

// File: tb/rtc_countdown_alarm_bench.sv
module rtc_countdown_alarm_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [4:0] O_CNT = 5'h0C, O_RUN = 5'h14, O_IEN = 5'h18, O_STA = 5'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rtc_countdown_alarm u_rtc_countdown_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] pack(int r);
    int s, m, h, d;
    s = r % 60;
    m = (r / 60) % 60;
    h = (r / 3600) % 24;
    d = r / 86400;
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(O_CNT, rd); check("R1 count", rd, 0);
    bus_rd(O_RUN, rd); check("R1 run", rd, 0);
    bus_rd(O_IEN, rd); check("R1 ien", rd, 0);
    bus_rd(O_STA, rd); check("R1 status", rd, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 layout and readback
    bus_wr(O_CNT, 32'h1FF7_3B3B); bus_rd(O_CNT, rd); check("R2 count max", rd, 32'h1FF7_3B3B);
    bus_wr(O_RUN, 32'hFFFF_FFFF); bus_rd(O_RUN, rd); check("R2 run bit8", rd, 32'h100);
    bus_wr(O_IEN, 32'hFFFF_FFFF); bus_rd(O_IEN, rd); check("R2 ien bit0", rd, 32'h1);
    bus_rd(5'h04, rd); check("R2 unmapped", rd, 0);
    bus_wr(O_RUN, 0); bus_wr(O_IEN, 0);

    // R3 run gating
    bus_wr(O_CNT, pack(100));
    repeat (5) pulse();
    bus_rd(O_CNT, rd); check("R3 stopped", rd, pack(100));
    bus_wr(O_RUN, 32'h1); pulse();
    bus_rd(O_CNT, rd); check("R3 bit0 not run", rd, pack(100));
    bus_wr(O_RUN, 32'h100); pulse();
    bus_rd(O_CNT, rd); check("R3 running", rd, pack(99));

    // R4 R5 sweep over seconds and minutes
    bus_wr(O_IEN, 1);
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 60; s++) begin
        int tot;
        tot = m * 60 + s;
        if (tot == 0) continue;
        bus_wr(O_STA, 1);
        bus_wr(O_CNT, pack(tot));
        for (int k = 1; k <= tot; k++) begin
          pulse();
          bus_rd(O_CNT, rd); check("R4 borrow step", rd, pack(tot - k));
        end
        bus_rd(O_STA, rd); check("R5 pending at zero", rd, 1);
        check("R6 irq at zero", 32'(irq), 1);
        pulse();
        bus_rd(O_CNT, rd); check("R5 no wrap", rd, 0);
      end
    end

    // R10 large-field borrows
    bus_wr(O_CNT, pack(86400)); pulse();
    bus_rd(O_CNT, rd); check("R10 day to hours", rd, pack(86399));
    bus_wr(O_CNT, pack(255 * 86400)); pulse();
    bus_rd(O_CNT, rd); check("R10 day 255", rd, pack(255 * 86400 - 1));
    bus_wr(O_CNT, pack(3600)); pulse();
    bus_rd(O_CNT, rd); check("R4 hour borrow", rd, pack(3599));

    // R6 gating of irq
    bus_wr(O_STA, 1);
    bus_wr(O_IEN, 0);
    bus_wr(O_CNT, pack(1)); pulse();
    bus_rd(O_STA, rd); check("R6 pending set", rd, 1);
    check("R6 irq masked", 32'(irq), 0);
    bus_wr(O_IEN, 1); check("R6 irq unmasked", 32'(irq), 1);
    repeat (4) @(negedge clk); check("R6 irq level", 32'(irq), 1);
    bus_wr(O_IEN, 0); check("R6 irq off", 32'(irq), 0);
    bus_wr(O_IEN, 1);

    // R7 write-one-to-clear
    bus_wr(O_STA, 0); bus_rd(O_STA, rd); check("R7 write zero kept", rd, 1);
    // R8 reload while pending, pending survives
    bus_wr(O_CNT, pack(1)); bus_rd(O_STA, rd); check("R8 pending survives load", rd, 1);
    // R7 final tick and clear in the same cycle: set wins
    @(negedge clk);
    tick = 1'b1; reg_en = 1'b1; reg_we = 1'b1; reg_addr = O_STA; reg_wdata = 1;
    @(negedge clk);
    tick = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    bus_rd(O_STA, rd); check("R7 set wins", rd, 1);
    bus_wr(O_STA, 1); bus_rd(O_STA, rd); check("R7 cleared", rd, 0);
    check("R7 irq cleared", 32'(irq), 0);

    // R8 count write beats tick
    bus_wr(O_CNT, pack(50)); pulse(); pulse();
    bus_rd(O_CNT, rd); check("R8 running", rd, pack(48));
    @(negedge clk);
    tick = 1'b1; reg_en = 1'b1; reg_we = 1'b1; reg_addr = O_CNT; reg_wdata = pack(10);
    @(negedge clk);
    tick = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    bus_rd(O_CNT, rd); check("R8 write wins", rd, pack(10));

    // R9 idle after zero writes
    bus_wr(O_CNT, 0); bus_wr(O_RUN, 0); bus_wr(O_IEN, 0); bus_wr(O_STA, 1);
    repeat (3) pulse();
    bus_rd(O_STA, rd); check("R9 idle no pending", rd, 0);
    check("R9 idle irq", 32'(irq), 0);
    bus_wr(O_RUN, 32'h100); bus_wr(O_IEN, 1);
    repeat (3) pulse();
    bus_rd(O_STA, rd); check("R9 zero load running", rd, 0);
    bus_rd(O_CNT, rd); check("R9 count zero", rd, 0);
    check("R9 irq low", 32'(irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule